// File: doc/BRIEF.md
# Boot-Stage Debug Access Controller

This block gates an external debug port. It decides whether a debugger may reach internal assets, and at what depth. The inputs are the current boot stage, the pass result from an external password checker, and a debug request tagged with the requester's privilege. The block drives three things: an enable for the debug port, a registered debug-mode flag, and the effective privilege level handed to the core.

A shield bit is held in a control register. Value 0 means the debugger is permitted and value 1 means it is disabled. The bit has a defined value from reset and can be written only once, to 1, in each reset session. The port stays closed at reset because a password pass is required first, and that pass is forgotten on every boot-stage change.

Elevation needs two things together: sufficient requester privilege and a passed password check. Full-depth access is granted only while the early boot stage is current. A grant in a later stage gives debug mode at the limited level.

Top module: `dbg_stage_gate`

## Requirements
- R1: During and after reset, dbg_mode, dbg_full and dbg_deny are 0, shield_q is 0, dbg_en is 0, and eff_priv equals cur_priv.
- R2: dbg_en is 1 exactly when shield_q is 0 (0 = debugger permitted, 1 = disabled) and a password pass has been recorded in the current boot stage.
- R3: A write with shield_we=1 and shield_wd=1 sets shield_q from the next cycle. While shield_q is 1, every further write is ignored until reset.
- R4: A pw_pass pulse is remembered. The memory is cleared by reset and by any cycle in which boot_stage differs from its value in the previous cycle. A request made in that change cycle is refused.
- R5: A request is granted only when all of these hold: req_priv is sufficient (01 supervisor or 11 machine; 00 user and the reserved 10 are insufficient), a pass is remembered, and shield_q is 0. dbg_mode rises one cycle after a granted request. Privilege alone or password alone does not grant.
- R6: A request that is not granted, and is not paired with an exit, gives dbg_deny=1 for exactly the following cycle, with dbg_mode 0 in that cycle.
- R7: eff_priv is 11 (machine) while dbg_mode is 1. Otherwise it follows cur_priv in the same cycle. Privilege encoding: 00 user, 01 supervisor, 11 machine.
- R8: dbg_exit clears dbg_mode one cycle later. It takes priority over a simultaneous request, and that request raises no deny.
- R9: dbg_full rises together with dbg_mode only if the grant occurred while boot_stage was 0. A grant in any other stage gives dbg_mode=1 with dbg_full=0.
- R10: An active debug mode ends one cycle after a boot-stage change. It also ends one cycle after shield_q becomes 1, which is two cycles after the shield write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_stage | input | STAGE_W | Current boot stage; 0 is the early window |
| shield_we | input | 1 | Shield register write strobe |
| shield_wd | input | 1 | Shield write data (1 = disable debugger) |
| pw_pass | input | 1 | Pass pulse from the password checker |
| dbg_req | input | 1 | Debug-mode entry request |
| dbg_exit | input | 1 | Debug-mode exit request |
| req_priv | input | 2 | Privilege of the requester |
| cur_priv | input | 2 | Normal current core privilege |
| dbg_en | output | 1 | Debug port enable |
| dbg_mode | output | 1 | Registered debug-mode flag |
| dbg_full | output | 1 | Full-depth asset access granted |
| dbg_deny | output | 1 | One-cycle refusal pulse |
| eff_priv | output | 2 | Effective privilege presented to the core |
| shield_q | output | 1 | Current shield bit |

## Verification
Some properties are checked on every cycle by assertions. These are: stickiness of the shield, no debug mode in the cycle after the shield reads 1, every rise of the mode flag being preceded by a request with both checks met, full access rising only after an early-stage grant, loss of the password memory after a stage change, and exclusivity of deny and mode. Other behaviour can only be shown by the bench's scenarios. That includes the exact combinations that must refuse (privilege alone, password alone, the change cycle itself), exit winning over a request, and the two-cycle lag from a shield write to the loss of debug mode. The bench also compares the combinational privilege override against cur_priv under random stimulus.

// File: rtl/dbg_stage_gate.sv
module dbg_stage_gate #(
  parameter int STAGE_W = 2,
  parameter logic [STAGE_W-1:0] EARLY_STAGE = '0,
  parameter logic [1:0] MIN_PRIV = 2'b01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAGE_W-1:0] boot_stage,
  input  logic               shield_we,
  input  logic               shield_wd,
  input  logic               pw_pass,
  input  logic               dbg_req,
  input  logic               dbg_exit,
  input  logic [1:0]         req_priv,
  input  logic [1:0]         cur_priv,
  output logic               dbg_en,
  output logic               dbg_mode,
  output logic               dbg_full,
  output logic               dbg_deny,
  output logic [1:0]         eff_priv,
  output logic               shield_q
);
  localparam logic [1:0] PRIV_M = 2'b11;
  localparam logic [1:0] PRIV_RSV = 2'b10;

  logic [STAGE_W-1:0] stage_q;
  logic pw_ok, stage_chg, priv_ok, grant, mode_d;

  assign stage_chg = boot_stage != stage_q;
  assign priv_ok   = (req_priv >= MIN_PRIV) && (req_priv != PRIV_RSV);
  assign grant     = dbg_req && !dbg_exit && priv_ok && pw_ok && !shield_q && !stage_chg;
  assign mode_d    = !dbg_exit && (grant || (dbg_mode && pw_ok && !shield_q && !stage_chg && !dbg_req));

  assign dbg_en   = !shield_q && pw_ok;
  assign eff_priv = dbg_mode ? PRIV_M : cur_priv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      pw_ok    <= 1'b0;
      shield_q <= 1'b0;
      dbg_mode <= 1'b0;
      dbg_full <= 1'b0;
      dbg_deny <= 1'b0;
    end else begin
      stage_q  <= boot_stage;
      pw_ok    <= stage_chg ? 1'b0 : (pw_ok || pw_pass);
      if (shield_we && !shield_q) shield_q <= shield_wd;
      dbg_mode <= mode_d;
      dbg_full <= grant ? (boot_stage == EARLY_STAGE) : (mode_d && dbg_full);
      dbg_deny <= dbg_req && !dbg_exit && !grant;
    end
  end

  p_shield_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(shield_q) |-> shield_q);

  p_stage_forgets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(boot_stage != stage_q) |-> !pw_ok);

  p_both_checks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_mode) |-> $past(dbg_req && pw_ok && req_priv >= MIN_PRIV && req_priv != PRIV_RSV));

  p_deny_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_deny |-> !dbg_mode);

  p_full_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_full) |-> $past(boot_stage == EARLY_STAGE));

  p_shield_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    shield_q |=> !dbg_mode);
endmodule

// File: tb/dbg_stage_gate_tb.sv
module dbg_stage_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] boot_stage = '0;
  logic shield_we = 0, shield_wd = 0, pw_pass = 0, dbg_req = 0, dbg_exit = 0;
  logic [1:0] req_priv = 2'b00, cur_priv = 2'b01;
  logic dbg_en, dbg_mode, dbg_full, dbg_deny, shield_q;
  logic [1:0] eff_priv;

  int compared = 0, mismatched = 0;

  logic m_shield, m_pw, m_mode, m_full, m_deny;
  logic [1:0] m_stage;

  dbg_stage_gate u_dut (
    .clk(clk), .rst_n(rst_n), .boot_stage(boot_stage), .shield_we(shield_we),
    .shield_wd(shield_wd), .pw_pass(pw_pass), .dbg_req(dbg_req), .dbg_exit(dbg_exit),
    .req_priv(req_priv), .cur_priv(cur_priv), .dbg_en(dbg_en), .dbg_mode(dbg_mode),
    .dbg_full(dbg_full), .dbg_deny(dbg_deny), .eff_priv(eff_priv), .shield_q(shield_q)
  );

  always #2 clk = ~clk;

  initial begin
    #800000;
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic chk(input string tag, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, got, exp);
    end
  endtask

  function automatic logic suff(input logic [1:0] p);
    return p == 2'b01 || p == 2'b11;
  endfunction

  task automatic model_reset();
    m_shield = 0; m_pw = 0; m_mode = 0; m_full = 0; m_deny = 0; m_stage = 0;
  endtask

  task automatic compare_all();
    chk("R5 dbg_mode", dbg_mode, m_mode);
    chk("R6 dbg_deny", dbg_deny, m_deny);
    chk("R9 dbg_full", dbg_full, m_full);
    chk("R3 shield_q", shield_q, m_shield);
    chk("R2 dbg_en", dbg_en, !m_shield && m_pw);
    chk("R7 eff_priv", eff_priv, m_mode ? 3 : cur_priv);
  endtask

  task automatic cycle();
    logic chg, grant, n_mode;
    chg    = boot_stage != m_stage;
    grant  = dbg_req && !dbg_exit && suff(req_priv) && m_pw && !m_shield && !chg;
    n_mode = !dbg_exit && (grant || (m_mode && m_pw && !m_shield && !chg && !dbg_req));
    @(posedge clk); #1;
    m_full   = grant ? (boot_stage == 2'd0) : (n_mode && m_full);
    m_deny   = dbg_req && !dbg_exit && !grant;
    m_pw     = chg ? 1'b0 : (m_pw || pw_pass);
    m_shield = m_shield || (shield_we && shield_wd);
    m_mode   = n_mode;
    m_stage  = boot_stage;
    compare_all();
    shield_we = 0; pw_pass = 0; dbg_req = 0; dbg_exit = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; model_reset();
    @(posedge clk); #1;
    chk("R1 mode in reset", dbg_mode, 0);
    chk("R1 shield in reset", shield_q, 0);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    chk("R1 dbg_mode", dbg_mode, 0);
    chk("R1 dbg_full", dbg_full, 0);
    chk("R1 dbg_deny", dbg_deny, 0);
    chk("R1 shield_q", shield_q, 0);
    chk("R1 dbg_en", dbg_en, 0);
    chk("R1 eff_priv", eff_priv, 1);
    rst_n = 1;
    cycle();

    dbg_req = 1; req_priv = 2'b11; cycle();
    chk("R5 privilege alone", dbg_mode, 0);
    chk("R6 deny pulse", dbg_deny, 1);
    cycle();
    chk("R6 deny one cycle", dbg_deny, 0);

    pw_pass = 1; cycle();
    chk("R4 pass remembered", dbg_en, 1);
    dbg_req = 1; req_priv = 2'b00; cycle();
    chk("R5 password alone", dbg_mode, 0);
    dbg_req = 1; req_priv = 2'b10; cycle();
    chk("R5 reserved priv", dbg_mode, 0);
    dbg_req = 1; req_priv = 2'b11; cur_priv = 2'b00; cycle();
    chk("R5 granted", dbg_mode, 1);
    chk("R9 full in early stage", dbg_full, 1);
    chk("R7 forced machine", eff_priv, 3);

    dbg_req = 1; dbg_exit = 1; cycle();
    chk("R8 exit wins", dbg_mode, 0);
    chk("R8 no deny", dbg_deny, 0);
    chk("R7 follows cur", eff_priv, 0);

    boot_stage = 2'd1; dbg_req = 1; req_priv = 2'b11; cycle();
    chk("R4 cleared on change", dbg_en, 0);
    chk("R4 change cycle refused", dbg_deny, 1);
    pw_pass = 1; cycle();
    dbg_req = 1; req_priv = 2'b01; cycle();
    chk("R9 limited mode", dbg_mode, 1);
    chk("R9 not full", dbg_full, 0);

    boot_stage = 2'd2; cycle();
    chk("R10 stage change ends mode", dbg_mode, 0);

    pw_pass = 1; cycle();
    dbg_req = 1; req_priv = 2'b11; cycle();
    chk("R10 regrant", dbg_mode, 1);
    shield_we = 1; shield_wd = 1; cycle();
    chk("R10 mode one cycle after write", dbg_mode, 1);
    chk("R3 shield set", shield_q, 1);
    cycle();
    chk("R10 mode dropped", dbg_mode, 0);
    shield_we = 1; shield_wd = 0; pw_pass = 1; cycle();
    chk("R3 write ignored", shield_q, 1);
    chk("R2 shield closes port", dbg_en, 0);

    do_reset();
    cycle();
    chk("R3 cleared by reset", shield_q, 0);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(15) == 0) boot_stage = 2'($urandom_range(3));
      shield_we = ($urandom_range(60) == 0);
      shield_wd = 1'($urandom_range(1));
      pw_pass   = ($urandom_range(9) < 3);
      dbg_req   = ($urandom_range(9) < 3);
      dbg_exit  = ($urandom_range(9) == 0);
      req_priv  = 2'($urandom_range(3));
      cur_priv  = 2'($urandom_range(3));
      if (i % 700 == 699) do_reset();
      cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule